// File: doc/BRIEF.md
# Flash Command Sequencer with Unlock-Bypass Mode

This block is the device-side command interpreter of a small 16-bit flash-like memory. It watches single-cycle bus write strobes and recognises two kinds of command sequence. The first is the ordinary program sequence, which needs two unlock writes, a program command and then the address/data write. The second is an unlock-bypass mode. In that mode each program needs only a command write and an address/data write, which roughly halves the bus traffic for bulk programming.

An accepted program ANDs the new word into a small internal register file. It then starts an internal busy timer whose length is a parameter. While the timer runs, or while a program error is latched, every read returns a status word instead of array data. In that word one bit pair inverts on each read and another bit pair reports the error. Software polls that word until the toggle stops and the error bit is clear, and issues a reset command to clear a latched error.

Top module: `flashcmd_seq`

## Requirements
- R1: After reset, busy is 0, the block is in normal (non-bypass) mode, and every array word reads as FFFFh.
- R2: The writes AAh at word address 555h, then 55h at 2AAh, then A0h at 555h, then one write of address/data, program the array word selected by the low ARRAY_AW address bits with the bitwise AND of the old word and the new data.
- R3: busy is 1 for exactly BUSY_CYCLES clocks, starting in the cycle after the programming write. Every write made while busy is 1 is ignored, and the command decoder does not advance.
- R4: A read registers its result on the output in the next cycle. While busy or a latched error is present, a read returns the status word: bits 14 and 6 both carry a toggle that inverts on every such read, bits 13 and 5 both carry the error flag, and all other bits are 0. Otherwise a read returns the addressed array word.
- R5: A program that would turn a stored 0 bit into 1 sets the error flag, and the stored word still becomes the AND. In normal mode the error stays set until a write with command byte F0h, which clears it and returns the decoder to idle.
- R6: In normal mode, any write that does not match the expected step of a sequence returns the decoder to idle, so a later address/data write programs nothing.
- R7: The writes AAh at 555h, then 55h at 2AAh, then 20h at 555h, enter bypass mode. The same prefix ending with 20h at any other address does not enter it.
- R8: In bypass mode, a write of A0h at any address followed by one address/data write performs a program as in R2 and R5.
- R9: In bypass mode, every write other than the bypass program and bypass exit commands is ignored, including F0h and the unlock writes, and the block stays in bypass mode.
- R10: Bypass mode is left by a write of 90h followed by a write of 00h, both at any address. After 90h, any other value keeps the block in bypass mode. After exit, a two-write A0h/data sequence no longer programs.
- R11: Commands are decoded from data bits 7:0 only; bits 15:8 of a command write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_re | input | 1 | Read strobe, one read per cycle it is high |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | 16 | Write data or command byte in bits 7:0 |
| bus_rdata | output | 16 | Registered read data or status word |
| busy | output | 1 | High while a program operation runs |

## Verification
The bound checker watches on every cycle that a busy period lasts exactly the configured length and starts only after a write. It also checks that writes during busy leave the decoder untouched, that consecutive status reads flip the toggle with both bit copies equal, that the error flag is held until a clear, and that bypass mode is entered and left only through writes carrying 20h and 00h. Only the bench's scenarios can show what the array ends up holding: the AND of each program over a sweep of every word in both modes, the rejection of broken or wrongly addressed sequences, and the ignored commands inside bypass mode. Those results need the full write history, which the checker does not model.

// File: rtl/flashcmd_pkg.sv
// Shared constants and types for the flash command sequencer.
// Assumes a 16-bit data bus and command bytes carried in data bits 7:0.
package flashcmd_pkg;

    localparam int DW     = 16;
    localparam int CMD_AW = 11;   // address bits compared on unlock cycles

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_BEXIT_A  = 8'h90;
    localparam logic [7:0] CMD_BEXIT_B  = 8'h00;
    localparam logic [7:0] CMD_CLEAR    = 8'hF0;

    localparam logic [CMD_AW-1:0] UNLOCK_ADR_A = 11'h555;
    localparam logic [CMD_AW-1:0] UNLOCK_ADR_B = 11'h2AA;

    typedef enum logic [2:0] {
        DS_IDLE,    // normal mode, waiting for first unlock
        DS_UNL1,    // first unlock seen
        DS_UNL2,    // second unlock seen
        DS_PROG,    // normal program command seen, next write is data
        DS_BIDLE,   // bypass mode, waiting for a command
        DS_BPROG,   // bypass program command seen, next write is data
        DS_BEXIT    // bypass exit first step seen
    } dec_state_t;

endpackage

// File: rtl/flashcmd_decode.sv
// Command sequence decoder.
// Tracks the unlock/program/bypass sequences on accepted writes and
// emits a one-cycle program strobe or error-clear strobe. Assumes wr_en
// is already gated off while an operation is busy.
module flashcmd_decode
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     data,
    output logic              prog_go,
    output logic              clr_err,
    output logic              in_bypass,
    output dec_state_t        state_o
);

    dec_state_t st, nxt;
    logic [7:0] cmd;
    logic       at_a, at_b;

    assign cmd  = data[7:0];
    assign at_a = (addr[CMD_AW-1:0] == UNLOCK_ADR_A);
    assign at_b = (addr[CMD_AW-1:0] == UNLOCK_ADR_B);

    // Next-state and strobe decode for one accepted write.
    always_comb begin
        nxt     = st;
        prog_go = 1'b0;
        clr_err = 1'b0;
        if (wr_en) begin
            case (st)
                DS_IDLE: begin
                    if (at_a && cmd == CMD_UNLOCK_A) nxt = DS_UNL1;
                    else clr_err = (cmd == CMD_CLEAR);
                end
                DS_UNL1: begin
                    if (at_b && cmd == CMD_UNLOCK_B) nxt = DS_UNL2;
                    else begin
                        nxt     = DS_IDLE;
                        clr_err = (cmd == CMD_CLEAR);
                    end
                end
                DS_UNL2: begin
                    if (at_a && cmd == CMD_PROGRAM)     nxt = DS_PROG;
                    else if (at_a && cmd == CMD_BYPASS) nxt = DS_BIDLE;
                    else begin
                        nxt     = DS_IDLE;
                        clr_err = (cmd == CMD_CLEAR);
                    end
                end
                DS_PROG: begin
                    prog_go = 1'b1;
                    nxt     = DS_IDLE;
                end
                DS_BIDLE: begin
                    if (cmd == CMD_PROGRAM)      nxt = DS_BPROG;
                    else if (cmd == CMD_BEXIT_A) nxt = DS_BEXIT;
                end
                DS_BPROG: begin
                    prog_go = 1'b1;
                    nxt     = DS_BIDLE;
                end
                DS_BEXIT: begin
                    nxt = (cmd == CMD_BEXIT_B) ? DS_IDLE : DS_BIDLE;
                end
                default: nxt = DS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= DS_IDLE;
        else        st <= nxt;
    end

    assign in_bypass = (st == DS_BIDLE) || (st == DS_BPROG) || (st == DS_BEXIT);
    assign state_o   = st;

endmodule

// File: rtl/flashcmd_engine.sv
// Program engine: busy timer, sticky error flag and status toggle.
// Assumes prog_go never arrives while busy and never with clr_err.
module flashcmd_engine
    import flashcmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_go,
    input  logic          bad_bits,
    input  logic          clr_err,
    input  logic          rd_en,
    output logic          busy,
    output logic          err,
    output logic          stat_mode,
    output logic [DW-1:0] stat_word
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          tog;
    logic          tog_next;

    // Busy timer: high for BUSY_CYCLES clocks after a program strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (prog_go) begin
            busy <= 1'b1;
            cnt  <= CW'(BUSY_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Error flag: set by an illegal 0-to-1 program, cleared by command.
    always_ff @(posedge clk) begin
        if (!rst_n)                   err <= 1'b0;
        else if (prog_go && bad_bits) err <= 1'b1;
        else if (clr_err)             err <= 1'b0;
    end

    assign stat_mode = busy | err;
    assign tog_next  = ~tog;

    // Toggle bit: inverts on every read served from the status word.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tog <= 1'b0;
        else if (rd_en && stat_mode) tog <= tog_next;
    end

    assign stat_word = {1'b0, tog_next, err, 6'b0, tog_next, err, 5'b0};

endmodule

// File: rtl/flashcmd_array.sv
// Small word array with AND-only program writes.
// Resets to all ones (erased). Read port is combinational.
module flashcmd_array
    import flashcmd_pkg::*;
#(
    parameter int ARRAY_AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ARRAY_AW-1:0] idx,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       word
);

    localparam int DEPTH = 1 << ARRAY_AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage: erase on reset, AND new data into the selected word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[idx] <= mem[idx] & wdata;
        end
    end

    assign word = mem[idx];

endmodule

// File: rtl/flashcmd_seq.sv
// Top of the flash command sequencer.
// Gates writes while busy, links decoder, engine and array, and
// registers the read result. Assumes bus_re and bus_we are not both high.
module flashcmd_seq
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int ARRAY_AW    = 4,
    parameter int BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              busy
);

    logic          wr_ok;
    logic          prog_go;
    logic          clr_err;
    logic          in_bypass;
    logic          err_q;
    logic          stat_mode;
    logic          bad_bits;
    logic [DW-1:0] stat_word;
    logic [DW-1:0] arr_word;
    dec_state_t    dec_state;

    assign wr_ok = bus_we & ~busy;

    flashcmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .addr     (bus_addr),
        .data     (bus_wdata),
        .prog_go  (prog_go),
        .clr_err  (clr_err),
        .in_bypass(in_bypass),
        .state_o  (dec_state)
    );

    flashcmd_array #(.ARRAY_AW(ARRAY_AW)) u_arr (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(prog_go),
        .idx  (bus_addr[ARRAY_AW-1:0]),
        .wdata(bus_wdata),
        .word (arr_word)
    );

    assign bad_bits = |(~arr_word & bus_wdata);

    flashcmd_engine #(.BUSY_CYCLES(BUSY_CYCLES)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_go  (prog_go),
        .bad_bits (bad_bits),
        .clr_err  (clr_err),
        .rd_en    (bus_re),
        .busy     (busy),
        .err      (err_q),
        .stat_mode(stat_mode),
        .stat_word(stat_word)
    );

    // Read register: status word during an operation or error, else array.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= stat_mode ? stat_word : arr_word;
    end

endmodule

// File: rtl/flashcmd_checker.sv
// Cycle checks for the flash command sequencer, bound into the top.
// Assumes the signals named in the bind below exist in flashcmd_seq.
module flashcmd_checker
    import flashcmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          bus_re,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          busy,
    input logic          err,
    input logic          clr_err,
    input logic          stat_mode,
    input logic          in_bypass,
    input dec_state_t    state
);

    int   run_cnt;
    logic rdq;
    logic have_prev;
    logic prev_tog;

    // Length of the current busy run, counted in the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= 0;
        else        run_cnt <= busy ? run_cnt + 1 : 0;
    end

    // Remember the toggle bit of the last status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdq       <= 1'b0;
            have_prev <= 1'b0;
            prev_tog  <= 1'b0;
        end else begin
            rdq <= bus_re && stat_mode;
            if (rdq) begin
                have_prev <= 1'b1;
                prev_tog  <= bus_rdata[6];
            end
        end
    end

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we)); // R2
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_cnt == BUSY_CYCLES); // R3
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= BUSY_CYCLES); // R3
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bus_we |=> $stable(state)); // R3
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        rdq && have_prev |-> bus_rdata[6] != prev_tog); // R4
    AST_STATUS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        rdq |-> bus_rdata[14] == bus_rdata[6] && bus_rdata[13] == bus_rdata[5]); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err && !clr_err |=> err); // R5
    AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_bypass) |-> $past(bus_we && bus_wdata[7:0] == 8'h20)); // R7
    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_bypass && !(bus_we && bus_wdata[7:0] == 8'h00) |=> in_bypass); // R9
    AST_BYPASS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_bypass) |-> $past(bus_we && bus_wdata[7:0] == 8'h00)); // R10

endmodule

bind flashcmd_seq flashcmd_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy     (busy),
    .err      (err_q),
    .clr_err  (clr_err),
    .stat_mode(stat_mode),
    .in_bypass(in_bypass),
    .state    (dec_state)
);

// File: tb/flashcmd_seq_test.sv
`timescale 1ns/1ps
// Bench for flashcmd_seq: sweeps every array word in both modes and
// checks reads against an arithmetic model of array, error and toggle.
module flashcmd_seq_test;

    localparam int BC = 16;
    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem_m [NW];
    logic        err_m = 1'b0;
    logic        tog_m = 1'b0;

    always #2.5 clk = ~clk;

    flashcmd_seq #(.ADDR_W(11), .ARRAY_AW(AW), .BUSY_CYCLES(BC)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy     (busy)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Read one word and compare with the model (status or array).
    task automatic rd_chk(input string tag, input logic [10:0] a);
        logic        st;
        logic [15:0] exp;
        @(negedge clk);
        st = busy | err_m;
        if (st) tog_m = ~tog_m;
        exp = st ? {1'b0, tog_m, err_m, 6'b0, tog_m, err_m, 5'b0} : mem_m[a[AW-1:0]];
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic model_prog(input logic [10:0] a, input logic [15:0] d);
        if ((~mem_m[a[AW-1:0]] & d) != 16'h0) err_m = 1'b1;
        mem_m[a[AW-1:0]] = mem_m[a[AW-1:0]] & d;
    endtask

    task automatic std_prog(input logic [10:0] a, input logic [15:0] d);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(a, d);
        model_prog(a, d);
    endtask

    task automatic byp_prog(input logic [10:0] a, input logic [15:0] d);
        wr(11'h3C1, 16'h00A0);
        wr(a, d);
        model_prog(a, d);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic enter_bypass();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h0020);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < NW; i++) mem_m[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 busy after reset", {15'b0, busy}, 16'h0);
        for (int a = 0; a < NW; a++) rd_chk("R1 erased word", 11'(a));

        // R2/R3: standard program on every word, exact busy length
        for (int a = 0; a < NW; a++) begin
            std_prog(11'(a), ~((16'h1 << a) | (16'h8000 >> a)));
            wait_idle(n);
            chk("R3 busy length", 16'(n), 16'(BC));
            rd_chk("R2 programmed word", 11'(a));
        end

        // R4/R3: status reads while busy, writes ignored while busy
        std_prog(11'd3, mem_m[3] & 16'h0F0F);
        rd_chk("R4 status read 1", 11'd3);
        rd_chk("R4 status read 2", 11'd3);
        rd_chk("R4 status read 3", 11'd9);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'd3, 16'h0000);
        wait_idle(n);
        rd_chk("R3 busy writes ignored", 11'd3);
        wr(11'd3, 16'h0000);
        chk("R3 decoder not advanced", {15'b0, busy}, 16'h0);
        rd_chk("R3 word after stray write", 11'd3);

        // R5: 0-to-1 program sets a sticky error, clear command removes it
        std_prog(11'd0, 16'hFFFF);
        wait_idle(n);
        chk("R5 busy length with error", 16'(n), 16'(BC));
        rd_chk("R5 error status", 11'd0);
        rd_chk("R5 error held", 11'd0);
        wr(11'd0, 16'h00F0);
        err_m = 1'b0;
        rd_chk("R5 cleared, array visible", 11'd0);

        // R6: broken sequences program nothing
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0056); wr(11'h555, 16'h00A0); wr(11'd1, 16'h0000);
        chk("R6 wrong second unlock", {15'b0, busy}, 16'h0);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A1); wr(11'd1, 16'h0000);
        chk("R6 wrong command", {15'b0, busy}, 16'h0);
        wr(11'h554, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd1, 16'h0000);
        chk("R6 wrong unlock address", {15'b0, busy}, 16'h0);
        rd_chk("R6 word untouched", 11'd1);

        // R11: upper data byte ignored in command writes
        wr(11'h555, 16'h12AA); wr(11'h2AA, 16'h3455); wr(11'h555, 16'hFFA0);
        wr(11'd2, mem_m[2] & 16'hF00F);
        model_prog(11'd2, mem_m[2] & 16'hF00F);
        chk("R11 program accepted", {15'b0, busy}, 16'h1);
        wait_idle(n);
        rd_chk("R11 programmed word", 11'd2);

        // R7: wrong address on the bypass command does not enter bypass
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h556, 16'h0020);
        wr(11'd4, 16'h00A0); wr(11'd4, 16'h0000);
        chk("R7 no bypass at wrong address", {15'b0, busy}, 16'h0);
        rd_chk("R7 word untouched", 11'd4);

        // R7/R8: bypass entry and two-write programs on every word
        enter_bypass();
        for (int a = 0; a < NW; a++) begin
            byp_prog(11'(a), mem_m[a] & ~(16'h0101 << (a % 8)));
            wait_idle(n);
            chk("R8 bypass busy length", 16'(n), 16'(BC));
            rd_chk("R8 bypass programmed word", 11'(a));
        end

        // R9: other commands ignored in bypass, clear command included
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0020);
        wr(11'd6, 16'h00F0);
        byp_prog(11'd6, mem_m[6] & 16'h7FFF);
        chk("R9 still in bypass", {15'b0, busy}, 16'h1);
        wait_idle(n);
        rd_chk("R9 bypass word", 11'd6);
        byp_prog(11'd7, 16'hFFFF);
        wait_idle(n);
        wr(11'd7, 16'h00F0);
        rd_chk("R9 clear ignored in bypass", 11'd7);

        // R10: 90h then other stays in bypass; 90h,00h exits
        wr(11'd0, 16'h0090); wr(11'd0, 16'h0011);
        wr(11'd0, 16'h00A0); wr(11'd8, mem_m[8]);
        chk("R10 still in bypass after 90h,11h", {15'b0, busy}, 16'h1);
        wait_idle(n);
        wr(11'h123, 16'h0090); wr(11'h7FE, 16'h0000);
        wr(11'd0, 16'h00F0);
        err_m = 1'b0;
        rd_chk("R10 normal mode clear works", 11'd7);
        wr(11'h3C1, 16'h00A0); wr(11'd9, 16'h0000);
        chk("R10 two-write program rejected", {15'b0, busy}, 16'h0);
        rd_chk("R10 word untouched", 11'd9);

        summary();
        $finish;
    end

endmodule